// File: doc/BRIEF.md
# Multi-Device Crosspoint Preset and Commit Sequencer

This block sits on the host side of a group of crosspoint route controllers that share one control bus. Each controller holds a staging register per output, written by a strobe while its chip select is low. Each also holds an active register per output. One shared commit strobe copies staging into active. The sequencer takes a batch of route changes as (device, output, input code) entries from a small command queue. It presets every affected device in turn and then issues a single commit to all devices, so the whole fabric switches in the same cycle. If requested, it then reads the active codes back and compares them with what it wrote.

A host loads entries while the sequencer is idle and pulses `start`, choosing with `verify_en` whether readback follows. `busy` stays high for the whole run. `done` pulses once at the end. A sticky `mismatch` flag, with the device and output of the first disagreement, reports a failed readback. Every bus timing minimum is a parameter counted in system clock cycles.

Top module: `xpt_salvo_seq`

## Requirements
- R1: An entry is accepted on a clock where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only when the sequencer is idle, the queue (depth `QDEPTH`) is not full, and `start` is low. Entries offered while `cmd_ready` is low are dropped and never reach the bus.
- R2: Entries are written one strobe each. Devices are handled in ascending index order, and entries for one device go out in queue order. When two entries name the same device and output, the one queued later ends up active.
- R3: Each write strobe is framed as follows. Exactly one chip select is low and `bus_dir` is low (0 = write). The input code is on `bus_a_out` and the output number is on `bus_b`. Address and chip select are stable for at least `T_ADDR_SU` cycles before `bus_wr_n` falls. `bus_wr_n` stays low at least `T_WR_LOW` cycles. Address and chip select stay unchanged at least `T_ADDR_HD` cycles after it rises.
- R4: A batch with at least one entry produces exactly one commit pulse (`bus_commit_n` low), after its last write. The commit comes at least `T_WR2CMT` cycles after the last write strobe rises, is at least `T_CMT_LOW` cycles wide, and is followed by at least `T_CMT2WR` cycles before any strobe or readback. No chip select is low during the commit.
- R5: `bus_rs_n` is low while `rst_n` is low and high afterwards. No commit starts until `bus_rs_n` has been high for at least `T_RS2CMT` cycles.
- R6: With `verify_en` sampled high at `start`, after the commit every output written in the batch is read once. The order is device-major and output-minor. For each read, `bus_dir` is high (1 = read), the device's chip select is low and `bus_b` holds the output. Each read window lasts at least `T_RB_SETTLE` cycles, and `bus_a_in` is sampled in its last cycle. Without verify, no read happens.
- R7: The first readback that differs from the expected code sets `mismatch` and latches `mm_dev`/`mm_out`. Later failures leave them unchanged. The flag holds until the next accepted `start` clears it.
- R8: `busy` is high from the cycle after an accepted `start` until the cycle after `done`. `done` is a single-cycle pulse, and the queue is empty afterwards.
- R9: `start` with an empty queue gives a `done` pulse with no write strobe, no commit and no readback.
- R10: Out of reset, `busy`, `done` and `mismatch` are low, all chip selects, `bus_wr_n` and `bus_commit_n` are high, and `bus_dir` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Route entry offered |
| cmd_ready | output | 1 | Entry can be accepted this cycle |
| cmd_dev | input | DEV_W | Target device index |
| cmd_out | input | OUT_W | Target output number |
| cmd_code | input | CODE_W | Input code to route to that output |
| start | input | 1 | Begin a batch with the queued entries |
| verify_en | input | 1 | Read back and compare after the commit |
| busy | output | 1 | Batch in progress |
| done | output | 1 | One-cycle end-of-batch pulse |
| mismatch | output | 1 | Sticky readback disagreement flag |
| mm_dev | output | DEV_W | Device of the first disagreement |
| mm_out | output | OUT_W | Output of the first disagreement |
| bus_cs_n | output | NUM_DEV | Per-device chip selects, active low |
| bus_dir | output | 1 | 0 = write staging, 1 = read active |
| bus_wr_n | output | 1 | Staging write strobe, active low |
| bus_commit_n | output | 1 | Shared commit strobe, active low |
| bus_rs_n | output | 1 | Shared controller reset line, active low |
| bus_b | output | OUT_W | Output select |
| bus_a_out | output | CODE_W | Input code driven during writes |
| bus_a_in | input | CODE_W | Active code returned during reads |

## Verification
A corrupt scan index or device counter shows up on the bus as a wrong chip-select sequence or a skipped write, and a missing write leaves a stale route after the commit. The bench's device model exposes this as a wrong active code as soon as the batch's commit lands. A timer loaded with the wrong count shortens a strobe, setup, hold or gap window, which the bench measures on the first write or commit of the batch. A wrong entry in the expected-route store, or a compare error, shows up at the readback of the affected output: either as a false `mismatch` or as the wrong `mm_dev`/`mm_out` for a fault injected into the device model.

// File: rtl/xpt_seq_pkg.sv
package xpt_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SCAN,
    S_WSET,
    S_WLOW,
    S_WHOLD,
    S_CGAP,
    S_CLOW,
    S_CREC,
    S_RSCAN,
    S_RWAIT,
    S_DONE
  } seq_state_e;

  // Flat index of a (device, output) pair, device-major.
  function automatic int flat_route(input int dev, input int out, input int n_out);
    return dev * n_out + out;
  endfunction

  function automatic int route_dev(input int idx, input int n_out);
    return idx / n_out;
  endfunction

  function automatic int route_out(input int idx, input int n_out);
    return idx % n_out;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to index n items (at least one).
  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/xpt_step_timer.sv
module xpt_step_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/xpt_cmd_queue.sv
module xpt_cmd_queue
  import xpt_seq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DEV_W  = 2,
  parameter int OUT_W  = 2,
  parameter int CODE_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = bits_for(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DEV_W-1:0]  push_dev,
  input  logic [OUT_W-1:0]  push_out,
  input  logic [CODE_W-1:0] push_code,
  input  logic              clear,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DEV_W-1:0]  rd_dev,
  output logic [OUT_W-1:0]  rd_out,
  output logic [CODE_W-1:0] rd_code,
  output logic [CNT_W-1:0]  count,
  output logic              full
);

  logic [DEV_W-1:0]  dev_mem  [DEPTH];
  logic [OUT_W-1:0]  out_mem  [DEPTH];
  logic [CODE_W-1:0] code_mem [DEPTH];
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (push) begin
      dev_mem[cnt_q[IDX_W-1:0]]  <= push_dev;
      out_mem[cnt_q[IDX_W-1:0]]  <= push_out;
      code_mem[cnt_q[IDX_W-1:0]] <= push_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (push)   cnt_q <= cnt_q + 1'b1;
  end

  assign rd_dev  = dev_mem[rd_idx];
  assign rd_out  = out_mem[rd_idx];
  assign rd_code = code_mem[rd_idx];
  assign count   = cnt_q;
  assign full    = (cnt_q == CNT_W'(DEPTH));

  assert_push_room_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));

endmodule

// File: rtl/xpt_route_shadow.sv
module xpt_route_shadow
  import xpt_seq_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int NUM_OUT = 4,
  parameter int CODE_W  = 4,
  localparam int DEV_W  = bits_for(NUM_DEV),
  localparam int OUT_W  = bits_for(NUM_OUT),
  localparam int MAP_N  = NUM_DEV * NUM_OUT,
  localparam int MAP_IW = bits_for(MAP_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_prog,
  input  logic              wr_en,
  input  logic [DEV_W-1:0]  wr_dev,
  input  logic [OUT_W-1:0]  wr_out,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [MAP_IW-1:0] rd_idx,
  output logic [CODE_W-1:0] rd_code,
  output logic              rd_prog
);

  logic [CODE_W-1:0] code_q [MAP_N];
  logic [MAP_N-1:0]  prog_q;
  int                wr_idx;

  assign wr_idx = flat_route(int'(wr_dev), int'(wr_out), NUM_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
      for (int i = 0; i < MAP_N; i++) code_q[i] <= '0;
    end else if (clr_prog) begin
      prog_q <= '0;
    end else if (wr_en) begin
      prog_q[wr_idx] <= 1'b1;
      code_q[wr_idx] <= wr_code;
    end
  end

  assign rd_code = code_q[rd_idx];
  assign rd_prog = prog_q[rd_idx];

  assert_clr_wr_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_prog && wr_en));

endmodule

// File: rtl/xpt_salvo_seq.sv
module xpt_salvo_seq
  import xpt_seq_pkg::*;
#(
  parameter int NUM_DEV     = 4,
  parameter int NUM_OUT     = 4,
  parameter int CODE_W      = 4,
  parameter int QDEPTH      = 16,
  parameter int T_ADDR_SU   = 2,
  parameter int T_WR_LOW    = 3,
  parameter int T_ADDR_HD   = 2,
  parameter int T_WR2CMT    = 4,
  parameter int T_CMT_LOW   = 3,
  parameter int T_CMT2WR    = 2,
  parameter int T_RB_SETTLE = 3,
  parameter int T_RS2CMT    = 5,
  localparam int DEV_W      = bits_for(NUM_DEV),
  localparam int OUT_W      = bits_for(NUM_OUT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [DEV_W-1:0]   cmd_dev,
  input  logic [OUT_W-1:0]   cmd_out,
  input  logic [CODE_W-1:0]  cmd_code,
  input  logic               start,
  input  logic               verify_en,
  output logic               busy,
  output logic               done,
  output logic               mismatch,
  output logic [DEV_W-1:0]   mm_dev,
  output logic [OUT_W-1:0]   mm_out,
  output logic [NUM_DEV-1:0] bus_cs_n,
  output logic               bus_dir,
  output logic               bus_wr_n,
  output logic               bus_commit_n,
  output logic               bus_rs_n,
  output logic [OUT_W-1:0]   bus_b,
  output logic [CODE_W-1:0]  bus_a_out,
  input  logic [CODE_W-1:0]  bus_a_in
);

  localparam int MAP_N  = NUM_DEV * NUM_OUT;
  localparam int MAP_W  = $clog2(MAP_N + 1);
  localparam int MAP_IW = bits_for(MAP_N);
  localparam int QCNT_W = $clog2(QDEPTH + 1);
  localparam int QIDX_W = bits_for(QDEPTH);
  localparam int T_MAX  = max_of(max_of(max_of(T_ADDR_SU, T_WR_LOW), max_of(T_ADDR_HD, T_WR2CMT)),
                                 max_of(max_of(T_CMT_LOW, T_CMT2WR), T_RB_SETTLE));
  localparam int T_W    = bits_for(T_MAX);
  localparam int RS_W   = $clog2(T_RS2CMT + 1);
  localparam logic [DEV_W-1:0] LAST_DEV = DEV_W'(NUM_DEV - 1);

  seq_state_e         state_q, state_d;
  logic [DEV_W-1:0]   dev_q, dev_d;
  logic [QCNT_W-1:0]  idx_q, idx_d;
  logic [MAP_W-1:0]   mi_q, mi_d;
  logic               verify_q, verify_d;
  logic [DEV_W-1:0]   cur_dev_q, cur_dev_d;
  logic [OUT_W-1:0]   cur_out_q, cur_out_d;
  logic [CODE_W-1:0]  cur_code_q, cur_code_d;
  logic               rs_q;
  logic [RS_W-1:0]    rs_cnt_q;
  logic               mismatch_q;
  logic [DEV_W-1:0]   mm_dev_q;
  logic [OUT_W-1:0]   mm_out_q;

  // Named internal events, used by the logic and by the assertions.
  logic               start_acc;
  logic               wr_rise_evt;
  logic               rb_sample_evt;
  logic               rb_bad;
  logic               rs_ok;
  logic               sel_active;
  logic               t_exp;
  logic               t_load;
  logic [T_W-1:0]     t_load_val;
  int                 dur;

  logic [DEV_W-1:0]   q_dev;
  logic [OUT_W-1:0]   q_out;
  logic [CODE_W-1:0]  q_code;
  logic [QCNT_W-1:0]  q_count;
  logic               q_full;
  logic [CODE_W-1:0]  sh_code;
  logic               sh_prog;
  logic [DEV_W-1:0]   rb_dev;
  logic [OUT_W-1:0]   rb_out;

  assign start_acc     = (state_q == S_IDLE) && start;
  assign wr_rise_evt   = (state_q == S_WLOW) && t_exp;
  assign rb_sample_evt = (state_q == S_RWAIT) && t_exp;
  assign rb_bad        = rb_sample_evt && (bus_a_in != sh_code);
  assign rs_ok         = (rs_cnt_q == RS_W'(T_RS2CMT));
  assign rb_dev        = DEV_W'(route_dev(int'(mi_q), NUM_OUT));
  assign rb_out        = OUT_W'(route_out(int'(mi_q), NUM_OUT));

  xpt_cmd_queue #(
    .DEPTH(QDEPTH), .DEV_W(DEV_W), .OUT_W(OUT_W), .CODE_W(CODE_W)
  ) queue_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (cmd_valid && cmd_ready),
    .push_dev (cmd_dev),
    .push_out (cmd_out),
    .push_code(cmd_code),
    .clear    (state_q == S_DONE),
    .rd_idx   (idx_q[QIDX_W-1:0]),
    .rd_dev   (q_dev),
    .rd_out   (q_out),
    .rd_code  (q_code),
    .count    (q_count),
    .full     (q_full)
  );

  xpt_route_shadow #(
    .NUM_DEV(NUM_DEV), .NUM_OUT(NUM_OUT), .CODE_W(CODE_W)
  ) shadow_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_prog(start_acc),
    .wr_en   (wr_rise_evt),
    .wr_dev  (cur_dev_q),
    .wr_out  (cur_out_q),
    .wr_code (cur_code_q),
    .rd_idx  (mi_q[MAP_IW-1:0]),
    .rd_code (sh_code),
    .rd_prog (sh_prog)
  );

  xpt_step_timer #(.W(T_W)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (t_load),
    .load_val(t_load_val),
    .expired (t_exp)
  );

  // Each timed state lasts dur cycles: the timer is loaded on entry.
  always_comb begin
    case (state_d)
      S_WSET:  dur = T_ADDR_SU;
      S_WLOW:  dur = T_WR_LOW;
      S_WHOLD: dur = T_ADDR_HD;
      S_CGAP:  dur = T_WR2CMT;
      S_CLOW:  dur = T_CMT_LOW;
      S_CREC:  dur = T_CMT2WR;
      S_RWAIT: dur = T_RB_SETTLE;
      default: dur = 1;
    endcase
  end

  assign t_load     = (state_d != state_q);
  assign t_load_val = T_W'(dur - 1);

  always_comb begin
    state_d    = state_q;
    dev_d      = dev_q;
    idx_d      = idx_q;
    mi_d       = mi_q;
    verify_d   = verify_q;
    cur_dev_d  = cur_dev_q;
    cur_out_d  = cur_out_q;
    cur_code_d = cur_code_q;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          verify_d = verify_en;
          dev_d    = '0;
          idx_d    = '0;
          state_d  = (q_count == '0) ? S_DONE : S_SCAN;
        end
      end
      S_SCAN: begin
        if (idx_q == q_count) begin
          if (dev_q == LAST_DEV) begin
            state_d = S_CGAP;
          end else begin
            dev_d = dev_q + 1'b1;
            idx_d = '0;
          end
        end else if (q_dev == dev_q) begin
          cur_dev_d  = q_dev;
          cur_out_d  = q_out;
          cur_code_d = q_code;
          state_d    = S_WSET;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      S_WSET:  if (t_exp) state_d = S_WLOW;
      S_WLOW:  if (t_exp) state_d = S_WHOLD;
      S_WHOLD: begin
        if (t_exp) begin
          idx_d   = idx_q + 1'b1;
          state_d = S_SCAN;
        end
      end
      S_CGAP:  if (t_exp && rs_ok) state_d = S_CLOW;
      S_CLOW:  if (t_exp) state_d = S_CREC;
      S_CREC: begin
        if (t_exp) begin
          mi_d    = '0;
          state_d = verify_q ? S_RSCAN : S_DONE;
        end
      end
      S_RSCAN: begin
        if (mi_q == MAP_W'(MAP_N)) begin
          state_d = S_DONE;
        end else if (sh_prog) begin
          cur_dev_d = rb_dev;
          cur_out_d = rb_out;
          state_d   = S_RWAIT;
        end else begin
          mi_d = mi_q + 1'b1;
        end
      end
      S_RWAIT: begin
        if (t_exp) begin
          mi_d    = mi_q + 1'b1;
          state_d = S_RSCAN;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      dev_q      <= '0;
      idx_q      <= '0;
      mi_q       <= '0;
      verify_q   <= 1'b0;
      cur_dev_q  <= '0;
      cur_out_q  <= '0;
      cur_code_q <= '0;
    end else begin
      state_q    <= state_d;
      dev_q      <= dev_d;
      idx_q      <= idx_d;
      mi_q       <= mi_d;
      verify_q   <= verify_d;
      cur_dev_q  <= cur_dev_d;
      cur_out_q  <= cur_out_d;
      cur_code_q <= cur_code_d;
    end
  end

  // Shared controller reset line and its release counter.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q     <= 1'b0;
      rs_cnt_q <= '0;
    end else begin
      rs_q <= 1'b1;
      if (rs_q && !rs_ok) rs_cnt_q <= rs_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mismatch_q <= 1'b0;
      mm_dev_q   <= '0;
      mm_out_q   <= '0;
    end else if (start_acc) begin
      mismatch_q <= 1'b0;
      mm_dev_q   <= '0;
      mm_out_q   <= '0;
    end else if (rb_bad && !mismatch_q) begin
      mismatch_q <= 1'b1;
      mm_dev_q   <= cur_dev_q;
      mm_out_q   <= cur_out_q;
    end
  end

  assign sel_active = (state_q == S_WSET) || (state_q == S_WLOW) ||
                      (state_q == S_WHOLD) || (state_q == S_RWAIT);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_cs
    assign bus_cs_n[g] = !(sel_active && (cur_dev_q == DEV_W'(g)));
  end

  assign bus_dir      = (state_q == S_RWAIT);
  assign bus_wr_n     = (state_q != S_WLOW);
  assign bus_commit_n = (state_q != S_CLOW);
  assign bus_rs_n     = rs_q;
  assign bus_b        = cur_out_q;
  assign bus_a_out    = cur_code_q;

  assign cmd_ready = (state_q == S_IDLE) && !q_full && !start;
  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);
  assign mismatch  = mismatch_q;
  assign mm_dev    = mm_dev_q;
  assign mm_out    = mm_out_q;

  assert_wr_framed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> ($countones(~bus_cs_n) == 1 && !bus_dir && bus_commit_n && bus_rs_n));

  assert_wr_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |=> ($stable(bus_a_out) && $stable(bus_b) && $stable(bus_cs_n)));

  assert_commit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_commit_n |-> (bus_wr_n && (&bus_cs_n) && !bus_dir));

  assert_rs_before_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_commit_n) |-> (rs_ok && bus_rs_n));

  assert_read_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dir |-> ($countones(~bus_cs_n) == 1 && bus_wr_n && bus_commit_n));

  assert_mm_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !start_acc) |=> (mismatch && $stable(mm_dev) && $stable(mm_out)));

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  assert_no_ready_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

endmodule

// File: tb/xpt_salvo_seq_tb_top.sv
module xpt_salvo_seq_tb_top;

  localparam int ND = 4, NO = 4, CW = 4, QD = 16;
  localparam int TS = 2, TP = 3, TH = 2, TWC = 4, TCL = 3, TCW = 2, TRB = 3, TRS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cmd_valid = 1'b0, start = 1'b0, verify_en = 1'b0;
  logic [1:0]    cmd_dev = '0, cmd_out = '0;
  logic [CW-1:0] cmd_code = '0;
  logic          cmd_ready, busy, done, mismatch;
  logic [1:0]    mm_dev, mm_out, bus_b;
  logic [ND-1:0] bus_cs_n;
  logic          bus_dir, bus_wr_n, bus_commit_n, bus_rs_n;
  logic [CW-1:0] bus_a_out, bus_a_in;

  xpt_salvo_seq #(
    .NUM_DEV(ND), .NUM_OUT(NO), .CODE_W(CW), .QDEPTH(QD),
    .T_ADDR_SU(TS), .T_WR_LOW(TP), .T_ADDR_HD(TH), .T_WR2CMT(TWC),
    .T_CMT_LOW(TCL), .T_CMT2WR(TCW), .T_RB_SETTLE(TRB), .T_RS2CMT(TRS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dev(cmd_dev), .cmd_out(cmd_out), .cmd_code(cmd_code), .start(start),
    .verify_en(verify_en), .busy(busy), .done(done), .mismatch(mismatch),
    .mm_dev(mm_dev), .mm_out(mm_out), .bus_cs_n(bus_cs_n), .bus_dir(bus_dir),
    .bus_wr_n(bus_wr_n), .bus_commit_n(bus_commit_n), .bus_rs_n(bus_rs_n),
    .bus_b(bus_b), .bus_a_out(bus_a_out), .bus_a_in(bus_a_in)
  );

  // Behavioural model of the crosspoint controllers.
  logic [CW-1:0] nxt [ND][NO];
  logic [CW-1:0] cur [ND][NO];
  logic          flt [ND][NO];
  logic [CW-1:0] em  [ND][NO];

  always @(posedge bus_wr_n)
    if (bus_dir === 1'b0)
      for (int d = 0; d < ND; d++) if (bus_cs_n[d] === 1'b0) nxt[d][bus_b] = bus_a_out;

  always @(negedge bus_commit_n)
    for (int d = 0; d < ND; d++) for (int o = 0; o < NO; o++) cur[d][o] = nxt[d][o];

  always_comb begin
    bus_a_in = '0;
    for (int d = 0; d < ND; d++)
      if (!bus_cs_n[d] && bus_dir) bus_a_in = bus_a_in | (cur[d][bus_b] ^ CW'(flt[d][bus_b]));
  end

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bus monitor, sampling between clock edges.
  int nwr, ncmt, nrd, ndone, v_wr, v_cmt, v_rs, v_rb;
  int wr_dev_log [64];
  int rd_dev_log [64];
  int rd_out_log [64];
  int pre_cnt, low_cnt, hold_cnt, since_wr, cmt_low, since_cmt, rs_cnt, rd_len;
  bit hold_act, prev_wr, prev_cmt, prev_rd;
  logic [ND-1:0] prev_cs;
  logic [CW-1:0] prev_a;
  logic [1:0]    prev_b;

  function automatic int sel_dev(input logic [ND-1:0] cs);
    for (int d = 0; d < ND; d++) if (!cs[d]) return d;
    return -1;
  endfunction

  initial begin
    nwr = 0; ncmt = 0; nrd = 0; ndone = 0; v_wr = 0; v_cmt = 0; v_rs = 0; v_rb = 0;
    pre_cnt = 0; low_cnt = 0; hold_cnt = 0; since_wr = 1000; cmt_low = 0;
    since_cmt = 1000; rs_cnt = 0; rd_len = 0; hold_act = 0;
    prev_wr = 1; prev_cmt = 1; prev_rd = 0; prev_cs = '1; prev_a = '0; prev_b = '0;
  end

  always @(negedge clk) if (rst_n) begin
    automatic bit same = (bus_cs_n == prev_cs) && (bus_a_out == prev_a) && (bus_b == prev_b);
    automatic bit rd = bus_dir && (bus_cs_n != '1);
    if (bus_rs_n) rs_cnt++;
    if (done) ndone++;
    // write framing (R3)
    if (bus_wr_n && bus_cs_n != '1 && !bus_dir) pre_cnt = (same && prev_wr) ? pre_cnt + 1 : 1;
    else if (bus_wr_n) pre_cnt = 0;
    if (!bus_wr_n && prev_wr) begin
      if (pre_cnt < TS || !same) v_wr++;
      if (since_cmt < TCW) v_cmt++;
      if (nwr < 64) wr_dev_log[nwr] = sel_dev(bus_cs_n);
      nwr++;
      low_cnt = 0;
    end
    if (!bus_wr_n) begin
      low_cnt++;
      if (!prev_wr && !same) v_wr++;
      since_wr = 0;
    end else since_wr++;
    if (hold_act && !(bus_wr_n && same)) begin
      if (hold_cnt < TH) v_wr++;
      hold_act = 0;
    end else if (hold_act) hold_cnt++;
    if (bus_wr_n && !prev_wr) begin
      if (low_cnt < TP) v_wr++;
      hold_act = 1;
      hold_cnt = 1;
    end
    // commit framing (R4, R5)
    if (!bus_commit_n && prev_cmt) begin
      ncmt++;
      if (since_wr < TWC) v_cmt++;
      if (rs_cnt < TRS) v_rs++;
      cmt_low = 0;
    end
    if (!bus_commit_n) begin cmt_low++; since_cmt = 0; end
    else since_cmt++;
    if (bus_commit_n && !prev_cmt && cmt_low < TCL) v_cmt++;
    // readback windows (R6)
    if (rd && !(prev_rd && same)) begin
      if (nrd < 64) begin rd_dev_log[nrd] = sel_dev(bus_cs_n); rd_out_log[nrd] = int'(bus_b); end
      nrd++;
      if (since_cmt < TCW) v_cmt++;
      rd_len = 1;
    end else if (rd) rd_len++;
    if (!rd && prev_rd && rd_len < TRB) v_rb++;
    prev_wr = bus_wr_n; prev_cmt = bus_commit_n; prev_rd = rd;
    prev_cs = bus_cs_n; prev_a = bus_a_out; prev_b = bus_b;
  end

  task automatic push(input int d, input int o, input int c);
    @(negedge clk);
    if (cmd_ready) em[d][o] = CW'(c);
    cmd_valid = 1'b1; cmd_dev = 2'(d); cmd_out = 2'(o); cmd_code = CW'(c);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_batch(input bit ver, input bit try_push);
    int guard;
    nwr = 0; ncmt = 0; nrd = 0; ndone = 0;
    @(negedge clk);
    start = 1'b1; verify_en = ver;
    @(negedge clk);
    start = 1'b0; verify_en = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    if (try_push) begin
      cmd_valid = 1'b1; cmd_dev = 2'd3; cmd_out = 2'd3; cmd_code = 4'd1;
      @(negedge clk);
      chk(cmd_ready == 1'b0, "R1 ready low while busy", int'(cmd_ready), 0);
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(guard < 5000, "R8 done reached", guard, 0);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R8 busy and done fall", int'(busy) + 2 * int'(done), 0);
    repeat (2) @(negedge clk);
    chk(ndone == 1, "R8 single done pulse", ndone, 1);
  endtask

  task automatic cmp_map(input string tag);
    int bad = 0;
    for (int d = 0; d < ND; d++) for (int o = 0; o < NO; o++) if (cur[d][o] !== em[d][o]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic chk_timing(input string tag);
    chk(v_wr == 0, {tag, " R3 write framing"}, v_wr, 0);
    chk(v_cmt == 0, {tag, " R4 commit gaps"}, v_cmt, 0);
    chk(v_rs == 0, {tag, " R5 reset release before commit"}, v_rs, 0);
    chk(v_rb == 0, {tag, " R6 read settle"}, v_rb, 0);
  endtask

  function automatic bit grouped();
    for (int i = 1; i < nwr && i < 64; i++) if (wr_dev_log[i] < wr_dev_log[i-1]) return 0;
    return 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int d = 0; d < ND; d++) for (int o = 0; o < NO; o++) begin
      nxt[d][o] = '0; cur[d][o] = '0; em[d][o] = '0; flt[d][o] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mismatch && bus_cs_n == '1 && bus_wr_n && bus_commit_n && !bus_dir,
        "R10 reset state", int'({busy, done, mismatch, bus_wr_n, bus_commit_n}), 3);
    chk(bus_rs_n == 1'b0, "R5 controller reset low in reset", int'(bus_rs_n), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(bus_rs_n == 1'b1, "R5 controller reset released", int'(bus_rs_n), 1);
    chk(cmd_ready == 1'b1, "R1 ready when idle", int'(cmd_ready), 1);

    // Batch A: mixed devices, repeated output, no verify.
    push(2, 1, 5); push(0, 3, 9); push(2, 1, 7); push(1, 0, 3); push(0, 0, 12);
    run_batch(1'b0, 1'b1);
    chk(nwr == 5, "R2 one strobe per entry", nwr, 5);
    chk(grouped(), "R2 writes grouped by ascending device", wr_dev_log[0], 0);
    chk(cur[2][1] == 4'd7, "R2 later entry wins", int'(cur[2][1]), 7);
    cmp_map("R2 active map after batch A");
    chk(ncmt == 1, "R4 one commit per batch", ncmt, 1);
    chk(nrd == 0, "R6 no readback without verify", nrd, 0);
    chk_timing("batch A");

    // Empty start; the entry offered while busy must have been dropped.
    run_batch(1'b0, 1'b0);
    chk(nwr == 0 && ncmt == 0 && nrd == 0, "R9 empty batch silent", nwr + ncmt + nrd, 0);
    chk(cur[3][3] == em[3][3], "R1 entry offered while busy dropped", int'(cur[3][3]), int'(em[3][3]));

    // Full sweep, output-major push order, with verify.
    for (int o = 0; o < NO; o++) for (int d = 0; d < ND; d++) push(d, o, (d * 5 + o * 3 + 1) % 16);
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R1 not ready when full", int'(cmd_ready), 0);
    push(0, 0, 15);
    run_batch(1'b1, 1'b0);
    chk(nwr == 16, "R2 sweep strobes", nwr, 16);
    chk(grouped(), "R2 sweep grouped", wr_dev_log[0], 0);
    cmp_map("R2 active map after sweep");
    chk(cur[0][0] == 4'd1, "R1 entry offered while full dropped", int'(cur[0][0]), 1);
    chk(nrd == 16, "R6 reads every programmed output", nrd, 16);
    begin
      automatic int bad = 0;
      for (int i = 0; i < 16; i++) if (rd_dev_log[i] != i / NO || rd_out_log[i] != i % NO) bad++;
      chk(bad == 0, "R6 readback order device-major", bad, 0);
    end
    chk(mismatch == 1'b0, "R7 no mismatch on clean readback", int'(mismatch), 0);
    chk_timing("sweep 1");

    // Second sweep with two corrupted readback paths.
    flt[3][0] = 1'b1; flt[2][1] = 1'b1;
    for (int o = 0; o < NO; o++) for (int d = 0; d < ND; d++) push(d, o, (d * 7 + o * 11 + 3) % 16);
    run_batch(1'b1, 1'b0);
    cmp_map("R2 active map after sweep 2");
    chk(mismatch == 1'b1, "R7 mismatch raised", int'(mismatch), 1);
    chk(mm_dev == 2'd2 && mm_out == 2'd1, "R7 first failing route kept",
        int'(mm_dev) * 4 + int'(mm_out), 9);
    repeat (5) @(negedge clk);
    chk(mismatch == 1'b1, "R7 mismatch sticky while idle", int'(mismatch), 1);
    chk_timing("sweep 2");

    // Partial batch: untouched outputs keep their routes; flag cleared by start.
    push(1, 2, 10);
    run_batch(1'b1, 1'b0);
    chk(nwr == 1 && nrd == 1, "R6 only programmed output read", nwr * 10 + nrd, 11);
    cmp_map("R2 untouched outputs unchanged");
    chk(mismatch == 1'b0, "R7 flag cleared at start", int'(mismatch), 0);
    chk_timing("partial");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule